// File: doc/BRIEF.md
# Virtual Supervisor Timer Compare with Time Offset

This block produces the timer-pending indication for a guest supervisor running under a hypervisor. It holds two 64-bit registers: a compare value and a time offset. Each cycle it adds the offset to the physical time count and discards any carry out of bit 63. It then tests the result against the compare value as unsigned numbers. The comparison result is registered, so any change on the time input or in either register reaches the output one clock edge later.

The visible pending bit combines two sources. One is a pending bit that the hypervisor injects in software, and it always passes through. The other is the registered comparison result, which counts only while the hypervisor-level enable input is high. With the enable low, the block behaves as if no compare hardware were present. The pending bit keeps its meaning whether or not the guest is running at that moment.

Software reaches both registers through a CSR port with 32-bit halves. Addresses 0x24D and 0x25D select the low and high halves of the compare value. Addresses 0x60A and 0x61A select the low and high halves of the offset.

Top module: `vtimer_cmp`

## Requirements
- R1: After reset, the compare value reads back as all ones in both halves, the offset reads back as zero in both halves, and the pending output equals the injected bit.
- R2: A write to address 0x24D replaces bits 31:0 of the compare value, and a write to 0x25D replaces bits 63:32. A read of either address returns that half in the same cycle.
- R3: A write to address 0x60A replaces bits 31:0 of the offset, and a write to 0x61A replaces bits 63:32. A read of either address returns that half.
- R4: The sum of time and offset is taken modulo 2^64 before the comparison.
- R5: The timer condition is true when the truncated sum is greater than or equal to the compare value, both taken as unsigned numbers. Equality counts as true.
- R6: With the enable input high, the pending output is the OR of the injected bit and the timer condition.
- R7: With the enable input low, the pending output equals the injected bit, whatever the timer condition is.
- R8: The timer condition reaches the output one clock edge after the time, offset and compare values it was computed from. A change of the time input is not visible before that edge.
- R9: A write to any other address changes neither register, and a read of any other address returns zero.
- R10: A write to one half of a register leaves the other half of that register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 32 | CSR write data (one half) |
| csr_rdata | output | 32 | CSR read data for csr_addr (combinational) |
| time_now | input | 64 | Physical time count |
| virt_enable | input | 1 | Hypervisor-level enable for the compare source |
| inject_pend | input | 1 | Pending bit injected by the hypervisor |
| virt_pend | output | 1 | Visible virtual timer-pending bit |

## Verification
A CSR write and an advance of the time input can land in the same clock cycle. On that edge the registered comparison is still computed from the old register contents and the new time. The bench provokes this case by changing the time input and the compare value together, and by moving the time across the compare value by exactly one count. It then checks the pending output just before and just after each edge, which shows whether the old or the new operands were used. The exact latency is judged against the one-edge rule. The wrap and unsigned corner cases are judged against expected values worked out by hand in the vector table.

// File: rtl/vtc_pkg.sv
package vtc_pkg;

    localparam logic [11:0] ADDR_CMP_LO_DEF = 12'h24D;
    localparam logic [11:0] ADDR_CMP_HI_DEF = 12'h25D;
    localparam logic [11:0] ADDR_OFS_LO_DEF = 12'h60A;
    localparam logic [11:0] ADDR_OFS_HI_DEF = 12'h61A;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_CMP  = 2'd1,
        TGT_OFS  = 2'd2
    } csr_tgt_e;

    typedef struct packed {
        csr_tgt_e tgt;
        logic     upper;
    } csr_dec_t;

    function automatic logic [63:0] all_ones64();
        return '1;
    endfunction

endpackage

// File: rtl/vtc_csr_decode.sv
module vtc_csr_decode
    import vtc_pkg::*;
#(
    parameter int          ADDR_W = 12,
    parameter logic [11:0] CMP_LO = ADDR_CMP_LO_DEF,
    parameter logic [11:0] CMP_HI = ADDR_CMP_HI_DEF,
    parameter logic [11:0] OFS_LO = ADDR_OFS_LO_DEF,
    parameter logic [11:0] OFS_HI = ADDR_OFS_HI_DEF
) (
    input  logic [ADDR_W-1:0] addr,
    output csr_dec_t          dec
);
    always_comb begin
        dec = '{tgt: TGT_NONE, upper: 1'b0};
        if (addr == ADDR_W'(CMP_LO))      dec = '{tgt: TGT_CMP, upper: 1'b0};
        else if (addr == ADDR_W'(CMP_HI)) dec = '{tgt: TGT_CMP, upper: 1'b1};
        else if (addr == ADDR_W'(OFS_LO)) dec = '{tgt: TGT_OFS, upper: 1'b0};
        else if (addr == ADDR_W'(OFS_HI)) dec = '{tgt: TGT_OFS, upper: 1'b1};
    end
endmodule

// File: rtl/vtc_split_reg.sv
module vtc_split_reg #(
    parameter int              PART_W = 32,
    parameter int              PARTS  = 2,
    parameter logic [63:0]     RST_VAL = '0,
    localparam int             WIDTH  = PART_W * PARTS,
    localparam int             SEL_W  = (PARTS > 1) ? $clog2(PARTS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  part_sel,
    input  logic [PART_W-1:0] wdata,
    output logic [WIDTH-1:0]  value
);
    for (genvar p = 0; p < PARTS; p++) begin : g_part
        always_ff @(posedge clk) begin
            if (rst)
                value[p*PART_W +: PART_W] <= RST_VAL[p*PART_W +: PART_W];
            else if (wr_en && part_sel == SEL_W'(p))
                value[p*PART_W +: PART_W] <= wdata;
        end
    end
endmodule

// File: rtl/vtc_hit_eval.sv
module vtc_hit_eval #(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TIME_W-1:0] time_now,
    input  logic [TIME_W-1:0] offset,
    input  logic [TIME_W-1:0] compare,
    output logic              hit_q
);
    logic [TIME_W-1:0] virt_time;
    logic              hit_d;

    always_comb begin
        virt_time = time_now + offset;
        hit_d     = (virt_time >= compare);
    end

    always_ff @(posedge clk) begin
        if (rst) hit_q <= 1'b0;
        else     hit_q <= hit_d;
    end
endmodule

// File: rtl/vtimer_cmp.sv
module vtimer_cmp
    import vtc_pkg::*;
#(
    parameter int          HALF_W = 32,
    parameter int          ADDR_W = 12,
    parameter logic [11:0] CMP_LO = ADDR_CMP_LO_DEF,
    parameter logic [11:0] CMP_HI = ADDR_CMP_HI_DEF,
    parameter logic [11:0] OFS_LO = ADDR_OFS_LO_DEF,
    parameter logic [11:0] OFS_HI = ADDR_OFS_HI_DEF,
    localparam int         TIME_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              csr_we,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic [HALF_W-1:0] csr_wdata,
    output logic [HALF_W-1:0] csr_rdata,
    input  logic [TIME_W-1:0] time_now,
    input  logic              virt_enable,
    input  logic              inject_pend,
    output logic              virt_pend
);
    csr_dec_t          dec;
    logic [TIME_W-1:0] cmp_q;
    logic [TIME_W-1:0] ofs_q;
    logic              hit_q;

    vtc_csr_decode #(
        .ADDR_W(ADDR_W), .CMP_LO(CMP_LO), .CMP_HI(CMP_HI),
        .OFS_LO(OFS_LO), .OFS_HI(OFS_HI)
    ) u_dec (
        .addr(csr_addr),
        .dec (dec)
    );

    vtc_split_reg #(.PART_W(HALF_W), .PARTS(2), .RST_VAL(all_ones64())) u_cmp (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (csr_we && dec.tgt == TGT_CMP),
        .part_sel(dec.upper),
        .wdata   (csr_wdata),
        .value   (cmp_q)
    );

    vtc_split_reg #(.PART_W(HALF_W), .PARTS(2), .RST_VAL(64'd0)) u_ofs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (csr_we && dec.tgt == TGT_OFS),
        .part_sel(dec.upper),
        .wdata   (csr_wdata),
        .value   (ofs_q)
    );

    vtc_hit_eval #(.TIME_W(TIME_W)) u_hit (
        .clk     (clk),
        .rst     (rst),
        .time_now(time_now),
        .offset  (ofs_q),
        .compare (cmp_q),
        .hit_q   (hit_q)
    );

    always_comb begin
        case (dec.tgt)
            TGT_CMP: csr_rdata = dec.upper ? cmp_q[TIME_W-1:HALF_W] : cmp_q[HALF_W-1:0];
            TGT_OFS: csr_rdata = dec.upper ? ofs_q[TIME_W-1:HALF_W] : ofs_q[HALF_W-1:0];
            default: csr_rdata = '0;
        endcase
    end

    assign virt_pend = inject_pend | (virt_enable & hit_q);
endmodule

// File: rtl/vtc_checker.sv
module vtc_checker #(
    parameter int HALF_W = 32,
    parameter int ADDR_W = 12,
    parameter logic [11:0] CMP_LO = 12'h24D,
    localparam int TIME_W = 2 * HALF_W
) (
    input logic              clk,
    input logic              rst,
    input logic              csr_we,
    input logic [ADDR_W-1:0] csr_addr,
    input logic [HALF_W-1:0] csr_wdata,
    input logic [TIME_W-1:0] time_now,
    input logic              virt_enable,
    input logic              inject_pend,
    input logic              virt_pend,
    input logic [TIME_W-1:0] cmp_q,
    input logic [TIME_W-1:0] ofs_q
);
    AST_INJECT_PASSES: assert property (@(posedge clk) disable iff (rst)
        inject_pend |-> virt_pend); // R6

    AST_DISABLED_ONLY_INJECT: assert property (@(posedge clk) disable iff (rst)
        !virt_enable |-> (virt_pend == inject_pend)); // R7

    AST_HIT_ONE_EDGE_LATE: assert property (@(posedge clk) disable iff (rst)
        (virt_enable && !inject_pend && !$past(rst))
            |-> (virt_pend == $past((TIME_W'(time_now + ofs_q)) >= cmp_q))); // R8

    AST_LOW_HALF_WRITE: assert property (@(posedge clk) disable iff (rst)
        (csr_we && csr_addr == ADDR_W'(CMP_LO)) |=> (cmp_q[HALF_W-1:0] == $past(csr_wdata))); // R2

    AST_OTHER_HALF_KEPT: assert property (@(posedge clk) disable iff (rst)
        (csr_we && csr_addr == ADDR_W'(CMP_LO))
            |=> (cmp_q[TIME_W-1:HALF_W] == $past(cmp_q[TIME_W-1:HALF_W]))); // R10
endmodule

bind vtimer_cmp vtc_checker #(.HALF_W(HALF_W), .ADDR_W(ADDR_W), .CMP_LO(CMP_LO)) u_vtc_checker (
    .clk        (clk),
    .rst        (rst),
    .csr_we     (csr_we),
    .csr_addr   (csr_addr),
    .csr_wdata  (csr_wdata),
    .time_now   (time_now),
    .virt_enable(virt_enable),
    .inject_pend(inject_pend),
    .virt_pend  (virt_pend),
    .cmp_q      (cmp_q),
    .ofs_q      (ofs_q)
);

// File: tb/test_vtimer_cmp.sv
`timescale 1ns/1ps
module test_vtimer_cmp;
    localparam logic [11:0] A_CL = 12'h24D;
    localparam logic [11:0] A_CH = 12'h25D;
    localparam logic [11:0] A_OL = 12'h60A;
    localparam logic [11:0] A_OH = 12'h61A;

    typedef struct packed {
        logic [63:0] t;
        logic [63:0] c;
        logic [63:0] o;
        logic        en;
        logic        inj;
        logic        exp;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{64'd100, 64'd200, 64'd0, 1'b1, 1'b0, 1'b0},                                   // R5 below
        '{64'd200, 64'd200, 64'd0, 1'b1, 1'b0, 1'b1},                                   // R5 equal
        '{64'd100, 64'd200, 64'd100, 1'b1, 1'b0, 1'b1},                                 // R4 offset
        '{64'hFFFF_FFFF_FFFF_FFF0, 64'h100, 64'h20, 1'b1, 1'b0, 1'b0},                  // R4 wrap
        '{64'hFFFF_FFFF_FFFF_FFF0, 64'h10, 64'h20, 1'b1, 1'b0, 1'b1},                   // R4 wrap eq
        '{64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 64'd0, 1'b1, 1'b0, 1'b1},   // R5 unsigned
        '{64'h100, 64'h8000_0000_0000_0000, 64'd0, 1'b1, 1'b0, 1'b0},                   // R5 unsigned
        '{64'd500, 64'd10, 64'd0, 1'b0, 1'b0, 1'b0},                                    // R7
        '{64'd5, 64'd10, 64'd0, 1'b0, 1'b1, 1'b1},                                      // R7
        '{64'd5, 64'd10, 64'd0, 1'b1, 1'b1, 1'b1}                                       // R6
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        csr_we = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic [63:0] time_now = '0;
    logic        virt_enable = 1'b0;
    logic        inject_pend = 1'b0;
    logic        virt_pend;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vtimer_cmp i_vtimer_cmp (
        .clk(clk), .rst(rst), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .time_now(time_now),
        .virt_enable(virt_enable), .inject_pend(inject_pend), .virt_pend(virt_pend)
    );

    task automatic check(input logic [63:0] got, input logic [63:0] exp, input string req);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic rd_check(input logic [11:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        csr_addr = a;
        #0.5;
        check({32'd0, csr_rdata}, {32'd0, exp}, req);
    endtask

    task automatic load(input logic [63:0] c, input logic [63:0] o);
        wr(A_CL, c[31:0]); wr(A_CH, c[63:32]);
        wr(A_OL, o[31:0]); wr(A_OH, o[63:32]);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        rd_check(A_CL, 32'hFFFF_FFFF, "R1 cmp lo");
        rd_check(A_CH, 32'hFFFF_FFFF, "R1 cmp hi");
        rd_check(A_OL, 32'h0, "R1 ofs lo");
        rd_check(A_OH, 32'h0, "R1 ofs hi");
        check({63'd0, virt_pend}, 64'd0, "R1 pend");

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            load(VECS[i].c, VECS[i].o);
            time_now = VECS[i].t; virt_enable = VECS[i].en; inject_pend = VECS[i].inj;
            @(negedge clk); @(negedge clk);
            check({63'd0, virt_pend}, {63'd0, VECS[i].exp}, $sformatf("R4/R5/R6/R7 vector %0d", i));
        end
        inject_pend = 1'b0; virt_enable = 1'b1;

        // R2 and R3 readback
        load(64'h1234_5678_9ABC_DEF0, 64'h0F0E_0D0C_0B0A_0908);
        rd_check(A_CL, 32'h9ABC_DEF0, "R2 cmp lo");
        rd_check(A_CH, 32'h1234_5678, "R2 cmp hi");
        rd_check(A_OL, 32'h0B0A_0908, "R3 ofs lo");
        rd_check(A_OH, 32'h0F0E_0D0C, "R3 ofs hi");

        // R10: single half write
        wr(A_CH, 32'hAAAA_5555);
        rd_check(A_CL, 32'h9ABC_DEF0, "R10 cmp lo kept");
        wr(A_OL, 32'h1111_2222);
        rd_check(A_OH, 32'h0F0E_0D0C, "R10 ofs hi kept");

        // R9: unknown address
        wr(12'h123, 32'hDEAD_BEEF);
        rd_check(12'h123, 32'h0, "R9 read zero");
        rd_check(A_CL, 32'h9ABC_DEF0, "R9 cmp lo unchanged");
        rd_check(A_CH, 32'hAAAA_5555, "R9 cmp hi unchanged");
        rd_check(A_OL, 32'h1111_2222, "R9 ofs lo unchanged");
        rd_check(A_OH, 32'h0F0E_0D0C, "R9 ofs hi unchanged");

        // R8: one-edge latency on a time step
        load(64'd1000, 64'd0);
        time_now = 64'd999;
        @(negedge clk); @(negedge clk);
        check({63'd0, virt_pend}, 64'd0, "R8 before cross");
        time_now = 64'd1000;
        #0.5;
        check({63'd0, virt_pend}, 64'd0, "R8 not before edge");
        @(negedge clk);
        check({63'd0, virt_pend}, 64'd1, "R8 after one edge");

        // R8: write and time change in the same cycle
        @(negedge clk);
        csr_we = 1'b1; csr_addr = A_CL; csr_wdata = 32'd2000; time_now = 64'd1500;
        @(negedge clk);
        csr_we = 1'b0;
        check({63'd0, virt_pend}, 64'd1, "R8 old compare used");
        @(negedge clk);
        check({63'd0, virt_pend}, 64'd0, "R8 new compare used");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule